// File: doc/BRIEF.md
# Buffered Synchronous Serial Transmitter

This block is the sending side of a synchronous serial port for codecs, line framers and SPI-style peripherals. A host writes 16-bit entries through a valid/ready handshake into a 16-entry transmit FIFO. A holding register builds each word from one or two entries, and a shifter sends it one bit at a time on `ser_data`. Each word is announced by a frame-sync pulse one bit period wide, placed in the bit period just before its first data bit.

Bit timing comes from a divider that counts ticks of a selectable source: the block's own clock, or rising edges of one of two external clock inputs. The divider makes a single-cycle strobe, not a gated clock. During each bit period `ser_strobe` is asserted for one clock cycle, and a receiver samples `ser_data` and `ser_fsync` in that cycle. The word length, the bit order, and the active levels of the strobe and the frame sync are set by static configuration inputs. Software changes them only while the block is idle.

The holding register refills while the current word is being shifted. When the next word is ready, its frame sync overlaps the last data bit of the current word, so back-to-back words leave no gap on the line. When no word is ready, the line goes quiet and a sticky underflow flag is raised.

Top module: `sertx_top`

## Requirements
- R1: `cfg_wlen` sets the word length: code 0 = 8 bits, 1 = 12, 2 = 16, 3 = 20, 4 = 24, 5 = 32 (codes 6 and 7 act as 8). After its frame sync, each word sends exactly that many data bits, taken from the low bits of the assembled word.
- R2: Bits go out most significant first. The only exception is word code 0 with `cfg_lsb_first` = 1, which sends least significant first. For every other length, `cfg_lsb_first` has no effect.
- R3: Each bit period lasts (`cfg_div` + 1) ticks of the selected source, and exactly one strobe cycle occurs per bit period.
- R4: `cfg_clk_src` selects the source: 0 or 3 = every clock cycle, 1 = rising edges of `ext_txclk`, 2 = rising edges of `ext_rxclk`.
- R5: The frame-sync output is active low when `cfg_fs_pol` = 1, otherwise active high. The strobe is active low when `cfg_clk_pol` = 1, otherwise active high.
- R6: The frame sync is active for exactly one strobe sample, the one just before the first data bit of a word. When a word follows the previous one without a break, that sample also carries the last data bit of the previous word, so there is no idle bit between them.
- R7: Words longer than 16 bits take two FIFO entries, the high half (bits 31:16) first. Shorter words take one entry.
- R8: The FIFO holds 16 entries. `wr_ready` is low while it is full, a write offered while `wr_ready` is low is dropped, and `fifo_level` counts the entries in the FIFO, not counting the holding register.
- R9: When a word ends with no next word ready, `uflow` is set and stays set until `uflow_clr` (a set in the same cycle takes priority). While idle, `ser_data` is 0 and neither the frame sync nor the strobe is active.
- R10: After reset, `fifo_level` = 0, `wr_ready` = 1, `uflow` = 0, `ser_data` = 0, and the frame sync and strobe are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the default bit-timing source |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wlen | input | 3 | Word length code |
| cfg_lsb_first | input | 1 | Least-significant-first request (8-bit only) |
| cfg_clk_src | input | 2 | Bit-timing source select |
| cfg_div | input | 8 | Divider value; bit period is value + 1 source ticks |
| cfg_fs_pol | input | 1 | Frame-sync active-low when 1 |
| cfg_clk_pol | input | 1 | Strobe active-low when 1 |
| ext_txclk | input | 1 | External clock, source code 1 |
| ext_rxclk | input | 1 | External clock, source code 2 |
| wr_valid | input | 1 | Host offers an entry |
| wr_data | input | 16 | Host entry |
| wr_ready | output | 1 | FIFO can accept an entry |
| fifo_level | output | 5 | Entries held in the FIFO |
| uflow_clr | input | 1 | Clears the underflow flag |
| uflow | output | 1 | Sticky underflow flag |
| ser_data | output | 1 | Serial data |
| ser_fsync | output | 1 | Frame sync |
| ser_strobe | output | 1 | One-cycle bit strobe |

## Verification
The bench decodes the serial line at every strobe and rebuilds each word. It checks the words across all six lengths, in both bit orders, with inverted polarities and from all three clock sources. A shifter that sends one bit too many or too few, or that reverses the order for a non-8-bit word, shows up as a word mismatch. A divider off by one tick shows up as a wrong spacing between strobes. The bench counts frame syncs that land on a data bit. A design that inserts an idle bit between queued words, or that fails to break the stream when the FIFO runs dry, reports the wrong overlap count or a missing underflow. Filling the FIFO while the bit clock is stalled confirms that exactly 16 entries plus one held word are accepted, and that every one of them later drains intact.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        WL_8  = 3'd0,
        WL_12 = 3'd1,
        WL_16 = 3'd2,
        WL_20 = 3'd3,
        WL_24 = 3'd4,
        WL_32 = 3'd5
    } wlen_e;

    typedef enum logic [1:0] {
        SRC_CORE     = 2'd0,
        SRC_EXT_TX   = 2'd1,
        SRC_EXT_RX   = 2'd2,
        SRC_CORE_ALT = 2'd3
    } clksrc_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } txst_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              half;   // high half captured, low half pending
    } hold_t;

    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        case (code)
            WL_12:   return 6'd12;
            WL_16:   return 6'd16;
            WL_20:   return 6'd20;
            WL_24:   return 6'd24;
            WL_32:   return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen
    import sertx_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      src_sel,
    input  logic [DIVW-1:0] div,
    input  logic            ext_tx,
    input  logic            ext_rx,
    output logic            bit_tick
);
    localparam int NEXT = 2;

    logic [NEXT-1:0] ext_in;
    logic [NEXT-1:0] ext_rise;
    logic            src_en;
    logic [DIVW-1:0] cnt;

    assign ext_in = {ext_rx, ext_tx};

    // Two-flop synchroniser plus edge history for each external clock
    for (genvar g = 0; g < NEXT; g++) begin : g_sync
        logic [2:0] sy;
        always_ff @(posedge clk) begin
            if (rst) sy <= '0;
            else     sy <= {sy[1:0], ext_in[g]};
        end
        assign ext_rise[g] = sy[1] & ~sy[2];
    end

    always_comb begin
        case (clksrc_e'(src_sel))
            SRC_EXT_TX: src_en = ext_rise[0];
            SRC_EXT_RX: src_en = ext_rise[1];
            default:    src_en = 1'b1;
        endcase
    end

    assign bit_tick = src_en && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (bit_tick) cnt <= '0;
        else if (src_en)   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [DW-1:0]   din,
    input  logic            pop,
    output logic [DW-1:0]   dout,
    output logic            full,
    output logic            empty,
    output logic [LVLW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == LVLW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        wlen,
    input  logic              lsb_first,
    input  logic              fs_pol,
    input  logic              clk_pol,
    input  logic              bit_tick,
    input  logic              fifo_empty,
    input  logic [HALF_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              uflow_clr,
    output logic              uflow,
    output logic              ser_data,
    output logic              ser_fsync,
    output logic              ser_strobe
);
    hold_t             hold;
    txst_e             st;
    logic [WORD_W-1:0] sh;
    logic [4:0]        idx;
    logic              fs_act, strb;
    logic [5:0]        wbits;
    logic              lsb_mode, two_part, last_bit, cur_bit, ends_dry;
    logic [5:0]        pos;

    assign wbits    = wlen_bits(wlen);
    assign lsb_mode = lsb_first && (wlen_e'(wlen) == WL_8);
    assign two_part = (wbits > 6'(HALF_W));
    assign pos      = lsb_mode ? {1'b0, idx} : (wbits - 6'd1 - {1'b0, idx});
    assign cur_bit  = sh[pos[4:0]];
    assign last_bit = ({1'b0, idx} == wbits - 6'd1);
    assign fifo_pop = !hold.valid && !fifo_empty;
    assign ends_dry = bit_tick && (st == TX_SEND) && last_bit && !hold.valid;

    // Holding register: built from one or two FIFO entries, drained on a bit tick
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (fifo_pop) begin
            if (two_part && !hold.half) begin
                hold.data[WORD_W-1:HALF_W] <= fifo_data;
                hold.half                  <= 1'b1;
            end else if (two_part) begin
                hold.data[HALF_W-1:0] <= fifo_data;
                hold.half             <= 1'b0;
                hold.valid            <= 1'b1;
            end else begin
                hold.data  <= {{(WORD_W-HALF_W){1'b0}}, fifo_data};
                hold.valid <= 1'b1;
            end
        end else if (bit_tick && hold.valid && (st == TX_IDLE || last_bit)) begin
            hold.valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TX_IDLE;
            sh       <= '0;
            idx      <= '0;
            fs_act   <= 1'b0;
            strb     <= 1'b0;
            ser_data <= 1'b0;
        end else if (bit_tick) begin
            if (st == TX_IDLE) begin
                ser_data <= 1'b0;
                fs_act   <= hold.valid;
                strb     <= hold.valid;
                if (hold.valid) begin
                    sh  <= hold.data;
                    idx <= '0;
                    st  <= TX_SEND;
                end
            end else begin
                ser_data <= cur_bit;
                strb     <= 1'b1;
                if (last_bit) begin
                    fs_act <= hold.valid;
                    idx    <= '0;
                    if (hold.valid) sh <= hold.data;
                    else            st <= TX_IDLE;
                end else begin
                    fs_act <= 1'b0;
                    idx    <= idx + 1'b1;
                end
            end
        end else begin
            strb <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            uflow <= 1'b0;
        else if (ends_dry)  uflow <= 1'b1;
        else if (uflow_clr) uflow <= 1'b0;
    end

    assign ser_fsync  = fs_act ^ fs_pol;
    assign ser_strobe = strb ^ clk_pol;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIVW       = 8,
    localparam int LVLW      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_wlen,
    input  logic              cfg_lsb_first,
    input  logic [1:0]        cfg_clk_src,
    input  logic [DIVW-1:0]   cfg_div,
    input  logic              cfg_fs_pol,
    input  logic              cfg_clk_pol,
    input  logic              ext_txclk,
    input  logic              ext_rxclk,
    input  logic              wr_valid,
    input  logic [HALF_W-1:0] wr_data,
    output logic              wr_ready,
    output logic [LVLW-1:0]   fifo_level,
    input  logic              uflow_clr,
    output logic              uflow,
    output logic              ser_data,
    output logic              ser_fsync,
    output logic              ser_strobe
);
    logic              bit_tick;
    logic              f_full, f_empty, f_pop;
    logic [HALF_W-1:0] f_data;

    assign wr_ready = !f_full;

    sertx_clkgen #(.DIVW(DIVW)) u_clk (
        .clk(clk), .rst(rst), .src_sel(cfg_clk_src), .div(cfg_div),
        .ext_tx(ext_txclk), .ext_rx(ext_rxclk), .bit_tick(bit_tick)
    );

    sertx_fifo #(.DW(HALF_W), .DEPTH(FIFO_DEPTH), .LVLW(LVLW)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_valid), .din(wr_data), .pop(f_pop),
        .dout(f_data), .full(f_full), .empty(f_empty), .level(fifo_level)
    );

    sertx_shifter u_shf (
        .clk(clk), .rst(rst), .wlen(cfg_wlen), .lsb_first(cfg_lsb_first),
        .fs_pol(cfg_fs_pol), .clk_pol(cfg_clk_pol), .bit_tick(bit_tick),
        .fifo_empty(f_empty), .fifo_data(f_data), .fifo_pop(f_pop),
        .uflow_clr(uflow_clr), .uflow(uflow), .ser_data(ser_data),
        .ser_fsync(ser_fsync), .ser_strobe(ser_strobe)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int LVLW  = 5,
    parameter int DEPTH = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [LVLW-1:0] fifo_level,
    input logic            uflow,
    input logic            uflow_clr,
    input logic            ser_fsync,
    input logic            ser_strobe,
    input logic            cfg_fs_pol,
    input logic            cfg_clk_pol
);
    logic fs_on, strobe_on;
    assign fs_on     = ser_fsync ^ cfg_fs_pol;
    assign strobe_on = ser_strobe ^ cfg_clk_pol;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, fifo_level} <= (LVLW+1)'(DEPTH));

    // R8
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (fifo_level <= $past(fifo_level)));

    // R8
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + 1'b1) &&
        ({1'b0, $past(fifo_level)} <= {1'b0, fifo_level} + 1'b1));

    // R9
    uflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (uflow && !uflow_clr) |=> uflow);

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fifo_level == '0 && !uflow && !fs_on && !strobe_on));

    // R6
    fs_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_on) |-> strobe_on);

endmodule

bind sertx_top sertx_chk #(.LVLW(LVLW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .fifo_level(fifo_level), .uflow(uflow), .uflow_clr(uflow_clr),
    .ser_fsync(ser_fsync), .ser_strobe(ser_strobe),
    .cfg_fs_pol(cfg_fs_pol), .cfg_clk_pol(cfg_clk_pol)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_wlen = '0;
    logic        cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_clk_src = '0;
    logic [7:0]  cfg_div = '0;
    logic        cfg_fs_pol = 1'b0;
    logic        cfg_clk_pol = 1'b0;
    logic        ext_txclk = 1'b0;
    logic        ext_rxclk = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic [4:0]  fifo_level;
    logic        uflow_clr = 1'b0;
    logic        uflow;
    logic        ser_data, ser_fsync, ser_strobe;

    always #10 clk = ~clk;

    sertx_top u0 (.*);

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit tx_run = 0, rx_run = 0;

    // Expected-stream model shared with the line monitor
    logic [31:0] exp_q[$];
    int  m_bits = 8, m_gap = 1;
    bit  m_lsb = 0, m_fsp = 0, m_clkp = 0;
    int  bits_left = 0, rx_pos = 0, last_cyc = 0;
    logic [31:0] rx_word = '0;
    int  fs_cnt = 0, ovl_cnt = 0, gap_err = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int bits_of(input int code);
        case (code)
            1: return 12; 2: return 16; 3: return 20; 4: return 24; 5: return 32;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int nb);
        return (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    endfunction

    initial forever begin
        @(posedge clk); cyc++;
    end

    // External clock generators: tx period 4 cycles, rx period 6 cycles
    initial forever begin
        @(posedge clk); #1;
        if (tx_run && (cyc % 2 == 0)) ext_txclk = ~ext_txclk;
        if (rx_run && (cyc % 3 == 0)) ext_rxclk = ~ext_rxclk;
    end

    // Line monitor: decode at each strobe sample
    always @(negedge clk) begin
        if (!rst && (ser_strobe ^ m_clkp)) begin
            bit had_data;
            had_data = (bits_left > 0);
            if (had_data) begin
                if (cyc - last_cyc != m_gap) gap_err++;
                if (m_lsb) rx_word[rx_pos] = ser_data;
                else       rx_word = {rx_word[30:0], ser_data};
                rx_pos++;
                bits_left--;
                if (bits_left == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(0, cur_req, rx_word, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(rx_word == e, cur_req, rx_word, e);
                    end
                end
            end
            if (ser_fsync ^ m_fsp) begin
                fs_cnt++;
                if (had_data) ovl_cnt++;
                bits_left = m_bits;
                rx_pos = 0;
                rx_word = '0;
            end
            last_cyc = cyc;
        end
    end

    task automatic set_cfg(input int wl, input bit lsb, input int src, input int dv,
                           input bit fsp, input bit clkp, input int src_period);
        @(posedge clk); #1;
        cfg_wlen = 3'(wl); cfg_lsb_first = lsb; cfg_clk_src = 2'(src);
        cfg_div = 8'(dv); cfg_fs_pol = fsp; cfg_clk_pol = clkp;
        m_bits = bits_of(wl); m_lsb = lsb && (wl == 0);
        m_fsp = fsp; m_clkp = clkp; m_gap = src_period * (dv + 1);
        @(posedge clk); #1;
    endtask

    task automatic write_entry(input logic [15:0] d);
        bit acc;
        acc = 0;
        wr_valid = 1'b1; wr_data = d;
        for (int k = 0; k < 5000 && !acc; k++) begin
            @(negedge clk); acc = wr_ready;
            @(posedge clk); #1;
        end
        wr_valid = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        exp_q.push_back(w & mask_of(m_bits));
        if (m_bits > 16) begin
            write_entry(w[31:16]);
            write_entry(w[15:0]);
        end else begin
            write_entry(w[15:0]);
        end
    endtask

    task automatic clear_uflow();
        uflow_clr = 1'b1; @(posedge clk); #1; uflow_clr = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 40000 && exp_q.size() != 0; k++) @(posedge clk);
        repeat (m_gap * 3 + 10) @(posedge clk);
        #1;
    endtask

    task automatic run_burst(input int n, input string req_timing);
        clear_uflow();
        fs_cnt = 0; ovl_cnt = 0; gap_err = 0;
        for (int i = 0; i < n; i++) push_word($urandom);
        drain();
        chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
        chk(fs_cnt == n, "R6", fs_cnt, n);
        chk(ovl_cnt == n - 1, "R6", ovl_cnt, n - 1);
        chk(gap_err == 0, req_timing, gap_err, 0);
        chk(uflow == 1'b1, "R9", uflow, 1);
        @(negedge clk);
        chk(ser_data == 1'b0, "R9", ser_data, 0);
        chk(ser_fsync == m_fsp, "R5", ser_fsync, m_fsp);
        chk(ser_strobe == m_clkp, "R5", ser_strobe, m_clkp);
        @(posedge clk); #1;
        clear_uflow();
        chk(uflow == 1'b0, "R9", uflow, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(fifo_level == 0, "R10", fifo_level, 0);
        chk(wr_ready == 1'b1, "R10", wr_ready, 1);
        chk(uflow == 1'b0, "R10", uflow, 0);
        chk(ser_data == 1'b0, "R10", ser_data, 0);
        chk(ser_fsync == 1'b0, "R10", ser_fsync, 0);
        chk(ser_strobe == 1'b0, "R10", ser_strobe, 0);
        @(posedge clk); #1;

        // R1, R7: every word length, random divider and order request
        for (int wl = 0; wl < 6; wl++) begin
            cur_req = (wl == 5) ? "R7" : "R1";
            set_cfg(wl, 1'($urandom % 2), 0, int'($urandom % 4), 0, 0, 1);
            run_burst(5, "R3");
        end

        // R2: LSB-first for 8-bit, ignored for 12-bit
        cur_req = "R2";
        set_cfg(0, 1, 0, 2, 0, 0, 1);
        run_burst(4, "R3");
        set_cfg(1, 1, 0, 1, 0, 0, 1);
        run_burst(4, "R3");
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        run_burst(3, "R3");

        // R5: inverted polarities, 20-bit words
        cur_req = "R5";
        set_cfg(3, 0, 0, 1, 1, 1, 1);
        run_burst(4, "R5");
        set_cfg(0, 0, 3, 2, 0, 0, 1);
        run_burst(3, "R4");

        // R4: external clocks
        cur_req = "R4";
        tx_run = 1;
        set_cfg(2, 0, 1, 1, 0, 0, 4);
        run_burst(3, "R4");
        tx_run = 0;
        rx_run = 1;
        set_cfg(4, 0, 2, 0, 0, 0, 6);
        run_burst(3, "R4");
        rx_run = 0;

        // R8: fill with the bit clock stalled
        cur_req = "R8";
        ext_txclk = 1'b0;
        set_cfg(0, 0, 1, 0, 0, 0, 1);
        clear_uflow();
        fs_cnt = 0; ovl_cnt = 0; gap_err = 0;
        begin
            int acc_n;
            acc_n = 0;
            for (int k = 0; k < 20; k++) begin
                logic [15:0] d;
                bit acc;
                d = 16'($urandom);
                wr_valid = 1'b1; wr_data = d;
                @(negedge clk); acc = wr_ready;
                @(posedge clk); #1;
                if (acc) begin
                    acc_n++;
                    exp_q.push_back({24'd0, d[7:0]});
                end
            end
            wr_valid = 1'b0;
            @(negedge clk);
            chk(acc_n == 17, "R8", acc_n, 17);
            chk(fifo_level == 16, "R8", fifo_level, 16);
            chk(wr_ready == 1'b0, "R8", wr_ready, 0);
            chk(fs_cnt == 0, "R4", fs_cnt, 0);
            @(posedge clk); #1;
        end
        cfg_clk_src = 2'd0;
        drain();
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
        chk(ovl_cnt == 16, "R6", ovl_cnt, 16);
        chk(fifo_level == 0, "R8", fifo_level, 0);
        chk(uflow == 1'b1, "R9", uflow, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule